// File: doc/BRIEF.md
# Folded Linear-Phase FIR Filter

This block is a fully parallel finite impulse response filter for a symmetric (linear-phase) impulse response with an even number of taps. The default build has 146 taps. Because coefficient `k` and coefficient `NTAPS-1-k` are equal, the two delay-line samples that share a coefficient are added first. Only that sum is multiplied. Half as many multipliers as taps are therefore needed: 73 in the default build.

The filter accepts at most one sample per clock, marked by `in_valid`. It returns one filtered sample per accepted input, marked by `out_valid`, after a fixed pipeline delay. All samples and coefficients are signed two's complement Q1.17 values (18 bits, LSB weight 2^-17).

The unique coefficients are passed in as one packed parameter vector `COEF`. Coefficient `k` sits in bits `[18k+17:18k]` and is paired with taps `k` and `NTAPS-1-k`. Products are summed in a registered binary adder tree 48 bits wide. The sum is then rounded back to Q1.17 and clamped.

Top module: `sym_fir`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_data` are 0. They stay 0 after release until the first result. Reset empties the delay line, so samples accepted before a reset never reach a later result.
- R2: The delay line moves only on cycles with `in_valid` high. Cycles with `in_valid` low leave the taps and pipeline contents unchanged. A stream with idle gaps therefore yields the same output values as the same samples sent back to back.
- R3: Every accepted sample gives exactly one `out_valid` pulse. The pulse comes LAT = 3 + ceil(log2(NTAPS/2)) clock edges later, which is 10 in the default build. Results come out in input order, and `out_valid` is never high otherwise.
- R4: Before rounding, the result for the newest sample x[n] is acc = sum over k = 0..NTAPS/2-1 of c[k]·(x[n-k] + x[n-(NTAPS-1)+k]). Samples older than reset count as 0. Equivalently, the impulse response is h[m] = c[m] for m < NTAPS/2 and h[m] = c[NTAPS-1-m] otherwise.
- R5: acc is in Q.34. The output is floor((acc + 2^16) / 2^17), so halfway cases round upward. For example, acc = -65536 gives 0, acc = +65536 gives 1, and acc = -131072 gives -1.
- R6: A rounded value above 131071 is output as 131071 (0x1FFFF). A rounded value below -131072 is output as -131072 (0x20000).
- R7: The pair sums are 19 bits wide and the accumulation is 48 bits wide, so no intermediate value wraps. Two mirrored taps at -131072 add to exactly -262144. A sustained full-scale input of either sign still yields the correctly clamped result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| in_valid | input | 1 | High when `in_data` holds a sample to accept |
| in_data | input | 18 | Input sample, signed Q1.17 |
| out_valid | output | 1 | High for one cycle per filtered result |
| out_data | output | 18 | Filtered sample, signed Q1.17, rounded and clamped |

## Verification
The bench keeps NTAPS = 146, 18-bit data and coefficients, and the 48-bit accumulator. It overrides `COEF` with its own vector. That vector holds the extreme codes -131072 and 131071, the exact rounding ties ±65536, the value 65535, and a large positive body that gives a DC gain far above one. With a raw impulse of 1, the outputs land exactly on the rounding ties. Full-scale steps of either sign drive the clamp and the 19-bit pair sums to their limits. Small random samples with random idle gaps, plus a reset in the middle of a burst, exercise the gating of the delay line and its clearing.

// File: rtl/sym_fir_pkg.sv
package sym_fir_pkg;
  localparam int DEF_TAPS  = 146;
  localparam int DEF_CW    = 18;
  localparam int DEF_PAIRS = DEF_TAPS / 2;

  // Placeholder ramp for standalone elaboration; real designs pass COEF.
  function automatic logic [DEF_PAIRS*DEF_CW-1:0] default_coefs();
    logic [DEF_PAIRS*DEF_CW-1:0] v;
    v = '0;
    for (int k = 0; k < DEF_PAIRS; k++) begin
      v[k*DEF_CW +: DEF_CW] = DEF_CW'(24 * (k + 1));
    end
    return v;
  endfunction
endpackage

// File: rtl/sym_fir_tapline.sv
module sym_fir_tapline #(
  parameter int NTAPS = 146,
  parameter int DW    = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic [DW-1:0]       din,
  output logic [NTAPS*DW-1:0] taps
);
  logic [NTAPS*DW-1:0] taps_nxt;

  always_comb begin
    taps_nxt = taps;
    if (shift_en) taps_nxt = {taps[(NTAPS-1)*DW-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps <= '0;
    else        taps <= taps_nxt;
  end

  // R2: a valid sample enters at tap 0 and the old tap 0 moves to tap 1
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (taps[DW-1:0] == $past(din)) && (taps[2*DW-1:DW] == $past(taps[DW-1:0])));

  // R2: idle cycles leave the delay line untouched
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(taps));
endmodule

// File: rtl/sym_fir_fold_mult.sv
module sym_fir_fold_mult #(
  parameter int NTAPS = 146,
  parameter int DW    = 18,
  parameter int CW    = 18,
  parameter logic [NTAPS/2*CW-1:0] COEF = '0,
  localparam int NPAIR = NTAPS / 2,
  localparam int PW    = DW + 1 + CW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [NTAPS*DW-1:0] taps,
  output logic [NPAIR*PW-1:0] prods
);
  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    localparam logic signed [CW-1:0] CF = COEF[k*CW +: CW];
    logic signed [DW-1:0] near_s, far_s;
    logic signed [DW:0]   pair_sum;
    logic signed [PW-1:0] prod_nxt, prod_q;

    assign near_s   = taps[k*DW +: DW];
    assign far_s    = taps[(NTAPS-1-k)*DW +: DW];
    assign pair_sum = {near_s[DW-1], near_s} + {far_s[DW-1], far_s};
    assign prod_nxt = pair_sum * CF;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  prod_q <= '0;
      else if (en) prod_q <= prod_nxt;
    end

    assign prods[k*PW +: PW] = prod_q;
  end

  // R2: the product stage only loads behind an accepted sample
  p_prod_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(prods));
endmodule

// File: rtl/sym_fir_sum_tree.sv
module sym_fir_sum_tree #(
  parameter int NPAIR = 73,
  parameter int PW    = 37,
  parameter int AW    = 48,
  localparam int LEVELS = $clog2(NPAIR),
  localparam int NLEAF  = 1 << LEVELS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LEVELS-1:0]     stage_en,
  input  logic [NPAIR*PW-1:0]   leaves,
  output logic signed [AW-1:0]  root
);
  logic signed [AW-1:0] lf [NLEAF];
  logic signed [AW-1:0] nd [NLEAF-1];

  for (genvar i = 0; i < NLEAF; i++) begin : g_leaf
    if (i < NPAIR) begin : g_used
      assign lf[i] = {{(AW-PW){leaves[i*PW+PW-1]}}, leaves[i*PW +: PW]};
    end else begin : g_pad
      assign lf[i] = '0;
    end
  end

  for (genvar d = 0; d < LEVELS; d++) begin : g_lvl
    for (genvar j = 0; j < (1 << d); j++) begin : g_node
      localparam int IDX = (1 << d) - 1 + j;
      logic signed [AW-1:0] sum_nxt;
      if (d == LEVELS - 1) begin : g_bot
        assign sum_nxt = lf[2*j] + lf[2*j+1];
      end else begin : g_mid
        assign sum_nxt = nd[2*IDX+1] + nd[2*IDX+2];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      nd[IDX] <= '0;
        else if (stage_en[LEVELS-1-d])   nd[IDX] <= sum_nxt;
      end
    end
  end

  assign root = nd[0];
endmodule

// File: rtl/sym_fir_round_sat.sv
module sym_fir_round_sat #(
  parameter int AW    = 48,
  parameter int DW    = 18,
  parameter int SHIFT = 17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [AW-1:0] acc,
  output logic [DW-1:0]        q
);
  localparam logic signed [AW-1:0] HALF = AW'(1) << (SHIFT - 1);
  localparam logic signed [AW-1:0] MAXV = (AW'(1) << (DW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] MINV = ~MAXV;

  logic signed [AW-1:0] rounded;
  logic [DW-1:0]        q_nxt;

  assign rounded = (acc + HALF) >>> SHIFT;

  always_comb begin
    if (rounded > MAXV)      q_nxt = MAXV[DW-1:0];
    else if (rounded < MINV) q_nxt = MINV[DW-1:0];
    else                     q_nxt = rounded[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_nxt;
  end

  // R6: clamp at the positive limit
  p_sat_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rounded > MAXV) |=> $signed(q) == $signed(MAXV[DW-1:0]));
  // R6: clamp at the negative limit
  p_sat_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rounded < MINV) |=> $signed(q) == $signed(MINV[DW-1:0]));
  // R5: in-range values pass through unchanged after rounding
  p_round_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rounded <= MAXV && rounded >= MINV) |=> q == $past(rounded[DW-1:0]));
endmodule

// File: rtl/sym_fir.sv
module sym_fir #(
  parameter int NTAPS = sym_fir_pkg::DEF_TAPS,
  parameter int DW    = 18,
  parameter int CW    = sym_fir_pkg::DEF_CW,
  parameter int AW    = 48,
  parameter logic [NTAPS/2*CW-1:0] COEF = sym_fir_pkg::default_coefs()
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int NPAIR  = NTAPS / 2;
  localparam int PW     = DW + 1 + CW;
  localparam int LEVELS = $clog2(NPAIR);
  localparam int LAT    = LEVELS + 3;

  logic [NTAPS*DW-1:0] taps;
  logic [NPAIR*PW-1:0] prods;
  logic signed [AW-1:0] total;
  logic [LAT-1:0]      vpipe, vpipe_nxt;

  // Valid chain: [0] taps loaded, [1] products, [2..LEVELS+1] tree, [LAT-1] output
  assign vpipe_nxt = {vpipe[LAT-2:0], in_valid};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vpipe <= '0;
    else        vpipe <= vpipe_nxt;
  end

  sym_fir_tapline #(.NTAPS(NTAPS), .DW(DW)) u_taps (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .din(in_data), .taps(taps));

  sym_fir_fold_mult #(.NTAPS(NTAPS), .DW(DW), .CW(CW), .COEF(COEF)) u_mult (
    .clk(clk), .rst_n(rst_n), .en(vpipe[0]), .taps(taps), .prods(prods));

  sym_fir_sum_tree #(.NPAIR(NPAIR), .PW(PW), .AW(AW)) u_tree (
    .clk(clk), .rst_n(rst_n), .stage_en(vpipe[LEVELS:1]), .leaves(prods), .root(total));

  sym_fir_round_sat #(.AW(AW), .DW(DW), .SHIFT(CW-1)) u_rnd (
    .clk(clk), .rst_n(rst_n), .en(vpipe[LEVELS+1]), .acc(total), .q(out_data));

  assign out_valid = vpipe[LAT-1];

  // Cycles since reset, saturating at LAT, to keep $past inside the post-reset window
  logic [$clog2(LAT+1)-1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           since_rst <= '0;
    else if (since_rst != LAT[$clog2(LAT+1)-1:0]) since_rst <= since_rst + 1'b1;
  end

  // R3: a result appears exactly LAT edges after each accepted sample
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == LAT[$clog2(LAT+1)-1:0]) |-> (out_valid == $past(in_valid, LAT)));

  // R1: nothing leaves the block in the first cycle after reset
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == '0) |-> (!out_valid && out_data == '0));
endmodule

// File: tb/sim_sym_fir.sv
module sim_sym_fir;
  localparam int NT  = 146;
  localparam int DW  = 18;
  localparam int CW  = 18;
  localparam int NP  = NT / 2;
  localparam int LAT = 10;   // 3 + ceil(log2(73)) per R3

  function automatic logic [NP*CW-1:0] tb_coefs();
    logic [NP*CW-1:0] v;
    int c;
    v = '0;
    for (int k = 0; k < NP; k++) begin
      if (k == 0)       c = -131072;
      else if (k == 1)  c = 65536;
      else if (k == 2)  c = -65536;
      else if (k == 3)  c = 65535;
      else if (k == NP-1) c = 131071;
      else              c = 20000 + ((k * 7919) % 30000);
      v[k*CW +: CW] = c[CW-1:0];
    end
    return v;
  endfunction

  localparam logic [NP*CW-1:0] TBC = tb_coefs();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic [DW-1:0] out_data;

  always #10 clk = ~clk;  // 50 MHz

  sym_fir #(.NTAPS(NT), .DW(DW), .CW(CW), .AW(48), .COEF(TBC)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int h[NT];
  int hist[NT];
  int exp_q[$];
  int sent_q[$];
  string tag_q[$];
  int n_in = 0;
  int n_out = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Direct (unfolded) reference: h[m] mirrored from the coefficient list, per R4/R5/R6
  function automatic int ref_out();
    longint acc = 0;
    longint r;
    for (int m = 0; m < NT; m++) acc += longint'(h[m]) * longint'(hist[m]);
    r = (acc + 65536) >>> 17;
    if (r > 131071) r = 131071;
    if (r < -131072) r = -131072;
    return int'(r);
  endfunction

  task automatic push(input int x, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x[DW-1:0];
    for (int m = NT - 1; m > 0; m--) hist[m] = hist[m-1];
    hist[0] = x;
    exp_q.push_back(ref_out());
    sent_q.push_back(cyc);
    tag_q.push_back(tag);
    n_in++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = '0;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_out++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected out_valid", 1, 0);
      end else begin
        int e, s;
        string t;
        e = exp_q.pop_front();
        s = sent_q.pop_front();
        t = tag_q.pop_front();
        chk($signed(out_data) == e, t, int'($signed(out_data)), e);
        chk((cyc - s) == LAT, "R3 latency", cyc - s, LAT);
      end
    end
    if (cyc == 100000) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < NT; m++) begin
      int k;
      k = (m < NP) ? m : (NT - 1 - m);
      h[m] = int'($signed(TBC[k*CW +: CW]));
      hist[m] = 0;
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(out_data == '0, "R1 out_data in reset", int'($signed(out_data)), 0);
    rst_n = 1'b1;
    idle(2);
    chk(out_valid == 1'b0, "R1 out_valid after release", int'(out_valid), 0);

    // R5: raw impulse of 1 lands on rounding ties (-1, 1, 0, 0, ...)
    push(1, "R5 rounding impulse");
    for (int i = 0; i < NT + 4; i++) push(0, "R5 rounding impulse");
    idle(3);

    // R4: full-scale impulse traces the mirrored response
    push(131071, "R4 impulse response");
    for (int i = 0; i < NT + 4; i++) push(0, "R4 impulse response");

    // R6: positive step drives the clamp high
    for (int i = 0; i < NT + 14; i++) push(131071, "R6 positive step");
    for (int i = 0; i < NT; i++) push(0, "R4 step decay");

    // R7: negative full-scale step, mirrored pairs at -131072
    for (int i = 0; i < NT + 14; i++) push(-131072, "R7 negative full scale");
    for (int i = 0; i < NT; i++) push(0, "R4 step decay");

    // R2: small random samples with random idle gaps
    for (int i = 0; i < 300; i++) begin
      push($urandom_range(0, 254) - 127, "R2 gapped stream");
      idle($urandom_range(0, 2));
    end

    // R4/R6: full-range random, back to back
    for (int i = 0; i < 200; i++) push($urandom_range(0, 262143) - 131072, "R4 random full range");

    // R1: reset in mid-burst clears pipeline and delay line
    for (int i = 0; i < 20; i++) push($urandom_range(0, 2000) - 1000, "R1 pre-reset burst");
    @(posedge clk);
    #3;
    rst_n = 1'b0;
    in_valid = 1'b0;
    exp_q.delete();
    sent_q.delete();
    tag_q.delete();
    n_in = 0;
    n_out = 0;
    for (int m = 0; m < NT; m++) hist[m] = 0;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R1 mid-run reset valid", int'(out_valid), 0);
    chk(out_data == '0, "R1 mid-run reset data", int'($signed(out_data)), 0);
    rst_n = 1'b1;
    push(131071, "R1 cleared delay line");
    for (int i = 0; i < NT + 4; i++) push(0, "R1 cleared delay line");

    // R3: drain, then one output per input and nothing left over
    idle(LAT + 6);
    chk(exp_q.size() == 0, "R3 pending results", exp_q.size(), 0);
    chk(n_out == n_in, "R3 one result per input", n_out, n_in);
    idle(5);
    chk(out_valid == 1'b0, "R3 quiet when idle", int'(out_valid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule